// File: doc/BRIEF.md
# Deep-FIFO Asynchronous Serial Port

This block is a full-duplex asynchronous serial port for a fixed frame: one low start bit, eight data bits sent least significant bit first, and one high stop bit, with no parity. Bytes written by the host go into a 64-entry transmit queue. A shifter drains the queue onto the serial output. Incoming frames are recovered by a 16x oversampling receiver and land in a 64-entry receive queue. Each received byte carries a framing-error flag.

A programmable divider sets the bit rate. It produces a 16x sample tick every `baud_div + 1` clocks, so common rates from 2400 to 921600 bit/s can be reached from a typical system clock. The host picks a receive threshold from six levels and a transmit threshold from three. The two threshold comparisons drive separate hit outputs, and an interrupt line is their OR. A loopback control feeds the transmitter's output straight into the receiver and keeps the external output idle, so the whole data path can be tested on the chip.

Top module: `uart_deep`

## Requirements
- R1: After reset, `txd` is 1, both queue counts are 0, `rx_avail` and `overrun` are 0, and `irq` is 1, because an empty transmit queue is at or below every transmit level.
- R2: With a constant `baud_div` = D, every bit after the start bit lasts exactly 16*(D+1) clocks on `txd`.
- R3: The transmit queue holds 64 bytes. A write while `tx_full` is 1 is dropped and leaves `tx_count` unchanged. The shifter takes the head byte as soon as it is idle.
- R4: Each byte is framed as a start bit of 0, eight data bits LSB first, and a stop bit of 1. In loopback, bytes come back in write order with `rd_ferr` = 0.
- R5: While `loopback` is 1 (and was 1 on the previous clock), `txd` stays 1.
- R6: The receiver samples each bit on oversample ticks 7, 8 and 9 and takes the majority. A start bit that is no longer low by that majority is discarded with no byte stored. A single-clock glitch inside a data bit does not change the byte.
- R7: A stop bit whose majority is 0 stores the byte with `rd_ferr` = 1.
- R8: The receive queue holds 64 bytes. A byte that arrives while it is full is discarded and sets `overrun`. `overrun` stays set until `ovr_clr` is pulsed.
- R9: `rx_lvl_sel` codes 0..5 select receive levels 1, 4, 8, 16, 32 and 48. Codes 6 and 7 also select 48. `rx_hit` = (`rx_count` >= level).
- R10: `tx_lvl_sel` codes 0, 1 and 2 select transmit levels 0, 4 and 8. Code 3 also selects 8. `tx_hit` = (`tx_count` <= level).
- R11: `irq` = `rx_hit` OR `tx_hit`. `rd_data`/`rd_ferr` show the oldest received byte. `rd_en` removes it, and has no effect when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | 16 | Oversample tick period minus one, in clocks |
| loopback | input | 1 | Route transmitter into receiver, hold `txd` idle |
| rx_lvl_sel | input | 3 | Receive threshold code |
| tx_lvl_sel | input | 2 | Transmit threshold code |
| wr_en | input | 1 | Write `wr_data` into transmit queue |
| wr_data | input | 8 | Byte to send |
| tx_full | output | 1 | Transmit queue full |
| tx_count | output | 7 | Transmit queue fill |
| rd_en | input | 1 | Remove the oldest received byte |
| rd_data | output | 8 | Oldest received byte |
| rd_ferr | output | 1 | Framing error flag of that byte |
| rx_avail | output | 1 | Receive queue not empty |
| rx_count | output | 7 | Receive queue fill |
| overrun | output | 1 | Sticky receive overrun flag |
| ovr_clr | input | 1 | Clear `overrun` |
| rx_hit | output | 1 | Receive fill at or above its level |
| tx_hit | output | 1 | Transmit fill at or below its level |
| irq | output | 1 | Interrupt request |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The assertions assume that `baud_div` and `loopback` do not change while a frame is being sent or received. They also assume that `rxd` idles high and that each of its levels lasts for whole bit periods, apart from deliberate one-clock glitches. The stimulus changes the divider and loopback only right after a reset or once both directions are idle. Serial frames on `rxd` are built in whole 16-clock bits at a divider of 0. Threshold codes are swept only while the queue fills are held still.

// File: rtl/uart_deep_pkg.sv
package uart_deep_pkg;
  localparam int FIFO_DEPTH = 64;
  localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1;
  localparam int DIV_W      = 16;
  localparam int OSR        = 16;
  localparam int DATA_W     = 8;

  typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  function automatic logic [CNT_W-1:0] rx_level(input logic [2:0] sel);
    case (sel)
      3'd0:    return CNT_W'(1);
      3'd1:    return CNT_W'(4);
      3'd2:    return CNT_W'(8);
      3'd3:    return CNT_W'(16);
      3'd4:    return CNT_W'(32);
      default: return CNT_W'(48);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] tx_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return CNT_W'(0);
      2'd1:    return CNT_W'(4);
      default: return CNT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         hit;

  always_comb begin
    hit   = (cnt_q >= div);
    cnt_d = hit ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tick  <= hit;
    end
  end

  // R2: with a divider above zero, ticks never come on consecutive clocks
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $stable(div) && div != '0) |=> !tick);
endmodule

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WIDTH-1:0]  din,
  input  logic              pop,
  output logic [WIDTH-1:0]  dout,
  output logic              full,
  output logic              empty,
  output logic [$clog2(DEPTH):0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  always_comb begin
    full    = (cnt_q == CW'(DEPTH));
    empty   = (cnt_q == '0);
    do_push = push && !full;
    do_pop  = pop && !empty;
    wp_d    = do_push ? wp_q + AW'(1) : wp_q;
    rp_d    = do_pop  ? rp_q + AW'(1) : rp_q;
    cnt_d   = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign count = cnt_q;

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R3: a push into a full queue without a pop leaves the fill alone
  a_r3_full_push_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_deep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_data,
  output logic              q_pop,
  output logic              line
);
  localparam int SW      = $clog2(OSR);
  localparam int FRAME_W = DATA_W + 2;
  localparam int BW      = $clog2(FRAME_W + 1);

  tx_state_e            st_q, st_d;
  logic [FRAME_W-1:0]   sh_q, sh_d;
  logic [SW-1:0]        tc_q, tc_d;
  logic [BW-1:0]        bc_q, bc_d;

  always_comb begin
    st_d  = st_q;
    sh_d  = sh_q;
    tc_d  = tc_q;
    bc_d  = bc_q;
    q_pop = (st_q == TX_IDLE) && !q_empty;
    if (q_pop) begin
      sh_d = {1'b1, q_data, 1'b0};
      tc_d = '0;
      bc_d = '0;
      st_d = TX_SEND;
    end else if (st_q == TX_SEND && tick) begin
      tc_d = tc_q + SW'(1);
      if (tc_q == SW'(OSR - 1)) begin
        sh_d = {1'b1, sh_q[FRAME_W-1:1]};
        bc_d = bc_q + BW'(1);
        if (bc_q == BW'(FRAME_W - 1)) st_d = TX_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TX_IDLE;
      sh_q <= '1;
      tc_q <= '0;
      bc_q <= '0;
    end else begin
      st_q <= st_d;
      sh_q <= sh_d;
      tc_q <= tc_d;
      bc_q <= bc_d;
    end
  end

  assign line = sh_q[0];

  a_r4_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_IDLE) |-> line);
  a_r4_start_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |=> !line);
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_deep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              ferr
);
  localparam int SW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [SW-1:0] S_A    = SW'(OSR/2 - 1);
  localparam logic [SW-1:0] S_B    = SW'(OSR/2);
  localparam logic [SW-1:0] S_C    = SW'(OSR/2 + 1);
  localparam logic [SW-1:0] S_LAST = SW'(OSR - 1);

  rx_state_e          st_q, st_d;
  logic [SW-1:0]      sp_q, sp_d;
  logic [BW-1:0]      bc_q, bc_d;
  logic               sa_q, sa_d, sb_q, sb_d;
  logic [DATA_W-1:0]  sh_q, sh_d, data_d;
  logic               valid_d, ferr_d, maj;

  always_comb begin
    maj     = (sa_q & sb_q) | (sa_q & line) | (sb_q & line);
    st_d    = st_q;
    sp_d    = sp_q;
    bc_d    = bc_q;
    sa_d    = sa_q;
    sb_d    = sb_q;
    sh_d    = sh_q;
    data_d  = data;
    ferr_d  = ferr;
    valid_d = 1'b0;
    if (tick) begin
      if (st_q == RX_IDLE) begin
        if (!line) begin
          st_d = RX_START;
          sp_d = SW'(1);
        end
      end else begin
        sp_d = sp_q + SW'(1);
        if (sp_q == S_A) sa_d = line;
        if (sp_q == S_B) sb_d = line;
        if (sp_q == S_C) begin
          case (st_q)
            RX_START: if (maj) st_d = RX_IDLE;
            RX_DATA: begin
              sh_d = {maj, sh_q[DATA_W-1:1]};
              bc_d = bc_q + BW'(1);
            end
            RX_STOP: begin
              valid_d = 1'b1;
              data_d  = sh_q;
              ferr_d  = !maj;
              st_d    = RX_IDLE;
            end
            default: ;
          endcase
        end
        if (sp_q == S_LAST) begin
          if (st_q == RX_START) begin
            st_d = RX_DATA;
            bc_d = '0;
          end else if (st_q == RX_DATA && bc_q == BW'(DATA_W)) begin
            st_d = RX_STOP;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      sp_q  <= '0;
      bc_q  <= '0;
      sa_q  <= 1'b1;
      sb_q  <= 1'b1;
      sh_q  <= '0;
      data  <= '0;
      ferr  <= 1'b0;
      valid <= 1'b0;
    end else begin
      st_q  <= st_d;
      sp_q  <= sp_d;
      bc_q  <= bc_d;
      sa_q  <= sa_d;
      sb_q  <= sb_d;
      sh_q  <= sh_d;
      data  <= data_d;
      ferr  <= ferr_d;
      valid <= valid_d;
    end
  end

  // R6: a byte is only delivered after the stop-bit decision
  a_r6_push_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($past(st_q) == RX_STOP));
  a_r6_no_start_from_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_IDLE && tick && line) |=> (st_q == RX_IDLE));
endmodule

// File: rtl/uart_deep.sv
module uart_deep
  import uart_deep_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   baud_div,
  input  logic               loopback,
  input  logic [2:0]         rx_lvl_sel,
  input  logic [1:0]         tx_lvl_sel,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               tx_full,
  output logic [CNT_W-1:0]   tx_count,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_ferr,
  output logic               rx_avail,
  output logic [CNT_W-1:0]   rx_count,
  output logic               overrun,
  input  logic               ovr_clr,
  output logic               rx_hit,
  output logic               tx_hit,
  output logic               irq,
  input  logic               rxd,
  output logic               txd
);
  logic [1:0]        rst_pipe;
  logic              rst_i;
  logic              tick;
  logic              txq_empty, txq_pop, tx_line;
  logic [DATA_W-1:0] txq_data;
  logic              rxq_full, rxq_empty;
  logic [DATA_W:0]   rxq_dout;
  logic              rb_valid, rb_ferr;
  logic [DATA_W-1:0] rb_data;
  logic [1:0]        rx_sync;
  logic              txd_d, ovr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  uart_baud #(.W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_i), .div(baud_div), .tick(tick));

  uart_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) txq_i (
    .clk(clk), .rst_n(rst_i), .push(wr_en), .din(wr_data), .pop(txq_pop),
    .dout(txq_data), .full(tx_full), .empty(txq_empty), .count(tx_count));

  uart_tx tx_i (
    .clk(clk), .rst_n(rst_i), .tick(tick), .q_empty(txq_empty),
    .q_data(txq_data), .q_pop(txq_pop), .line(tx_line));

  uart_rx rx_i (
    .clk(clk), .rst_n(rst_i), .tick(tick), .line(rx_sync[1]),
    .valid(rb_valid), .data(rb_data), .ferr(rb_ferr));

  uart_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W + 1)) rxq_i (
    .clk(clk), .rst_n(rst_i), .push(rb_valid), .din({rb_ferr, rb_data}),
    .pop(rd_en), .dout(rxq_dout), .full(rxq_full), .empty(rxq_empty),
    .count(rx_count));

  always_comb begin
    txd_d  = loopback ? 1'b1 : tx_line;
    ovr_d  = overrun;
    if (ovr_clr) ovr_d = 1'b0;
    if (rb_valid && rxq_full) ovr_d = 1'b1;
    rx_hit = (rx_count >= rx_level(rx_lvl_sel));
    tx_hit = (tx_count <= tx_level(tx_lvl_sel));
    irq    = rx_hit | tx_hit;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rx_sync <= 2'b11;
      txd     <= 1'b1;
      overrun <= 1'b0;
    end else begin
      rx_sync <= {rx_sync[0], loopback ? tx_line : rxd};
      txd     <= txd_d;
      overrun <= ovr_d;
    end
  end

  assign rd_data  = rxq_dout[DATA_W-1:0];
  assign rd_ferr  = rxq_dout[DATA_W];
  assign rx_avail = !rxq_empty;

  a_r5_loopback_quiet: assert property (@(posedge clk) disable iff (!rst_i)
    (loopback && $past(loopback)) |-> txd);
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_i)
    (overrun && !ovr_clr) |=> overrun);
  a_r8_overrun_cause: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(overrun) |-> ($past(rx_count) == CNT_W'(FIFO_DEPTH)));
endmodule

// File: tb/uart_deep_tb.sv
module uart_deep_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] baud_div;
  logic        loopback, wr_en, rd_en, ovr_clr, rxd;
  logic [2:0]  rx_lvl_sel;
  logic [1:0]  tx_lvl_sel;
  logic [7:0]  wr_data, rd_data;
  logic        tx_full, rd_ferr, rx_avail, overrun, rx_hit, tx_hit, irq, txd;
  logic [6:0]  tx_count, rx_count;

  int checks = 0;
  int fails  = 0;
  bit model_on = 1'b0;
  bit lb_prev  = 1'b0;
  bit done     = 1'b0;
  byte unsigned exp_q[$];

  always #2 clk = ~clk;

  uart_deep dut_i (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .loopback(loopback),
    .rx_lvl_sel(rx_lvl_sel), .tx_lvl_sel(tx_lvl_sel), .wr_en(wr_en),
    .wr_data(wr_data), .tx_full(tx_full), .tx_count(tx_count), .rd_en(rd_en),
    .rd_data(rd_data), .rd_ferr(rd_ferr), .rx_avail(rx_avail),
    .rx_count(rx_count), .overrun(overrun), .ovr_clr(ovr_clr),
    .rx_hit(rx_hit), .tx_hit(tx_hit), .irq(irq), .rxd(rxd), .txd(txd));

  function automatic int ref_rx_lvl(input int s);
    int t[8] = '{1, 4, 8, 16, 32, 48, 48, 48};
    return t[s];
  endfunction

  function automatic int ref_tx_lvl(input int s);
    int t[4] = '{0, 4, 8, 8};
    return t[s];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle-by-cycle model of thresholds, interrupt and loopback quiet line
  always @(negedge clk) begin
    if (model_on) begin
      chk(rx_hit == (int'(rx_count) >= ref_rx_lvl(int'(rx_lvl_sel))), "R9 rx_hit", int'(rx_hit),
          int'(int'(rx_count) >= ref_rx_lvl(int'(rx_lvl_sel))));
      chk(tx_hit == (int'(tx_count) <= ref_tx_lvl(int'(tx_lvl_sel))), "R10 tx_hit", int'(tx_hit),
          int'(int'(tx_count) <= ref_tx_lvl(int'(tx_lvl_sel))));
      chk(irq == (rx_hit | tx_hit), "R11 irq", int'(irq), int'(rx_hit | tx_hit));
      if (lb_prev && loopback) chk(txd == 1'b1, "R5 txd quiet", int'(txd), 1);
      chk(rx_count <= 7'd64, "R8 rx bound", int'(rx_count), 64);
    end
    lb_prev = loopback;
  end

  task automatic do_reset();
    model_on = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; ovr_clr = 1'b0; rxd = 1'b1;
    wr_data = '0; loopback = 1'b0; baud_div = '0; rx_lvl_sel = '0; tx_lvl_sel = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 model_on = 1'b1;
  endtask

  task automatic wr(input byte unsigned b);
    @(posedge clk); #1 wr_en = 1'b1; wr_data = b;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd_chk(input byte unsigned b, input bit fe, input string req);
    @(negedge clk);
    chk(rx_avail == 1'b1, req, int'(rx_avail), 1);
    chk(rd_data == b, req, int'(rd_data), int'(b));
    chk(rd_ferr == fe, req, int'(rd_ferr), int'(fe));
    @(posedge clk); #1 rd_en = 1'b1;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic drain_tx();
    @(negedge clk);
    while (tx_count != 0) @(negedge clk);
    repeat (400) @(negedge clk);
  endtask

  // divider 0: one bit is 16 clocks
  task automatic ext_frame(input byte unsigned b, input bit stop, input bit glitch);
    @(posedge clk); #1 rxd = 1'b0;
    repeat (16) @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      #1 rxd = b[i];
      for (int c = 0; c < 16; c++) begin
        @(posedge clk);
        #1 rxd = (glitch && c == 7) ? ~b[i] : b[i];
      end
    end
    #1 rxd = stop;
    repeat (16) @(posedge clk);
    #1 rxd = 1'b1;
    repeat (48) @(posedge clk);
  endtask

  initial begin
    int width;
    do_reset();

    // R1 reset state
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd", int'(txd), 1);
    chk(tx_count == 0, "R1 tx_count", int'(tx_count), 0);
    chk(rx_count == 0 && !rx_avail, "R1 rx empty", int'(rx_count), 0);
    chk(overrun == 1'b0, "R1 overrun", int'(overrun), 0);
    chk(irq == 1'b1, "R1 irq", int'(irq), 1);

    // R2 bit timing: 0x55 gives start 0 then bit0=1 then bit1=0
    #1 baud_div = 16'd3;
    wr(8'h55);
    @(negedge clk);
    while (txd != 1'b0) @(negedge clk);
    while (txd != 1'b1) @(negedge clk);
    width = 0;
    while (txd == 1'b1) begin width++; @(negedge clk); end
    chk(width == 64, "R2 bit width", width, 64);
    drain_tx();

    // R3 / R10: slow divider, fill transmit queue
    do_reset();
    #1 baud_div = 16'd200;
    for (int i = 0; i < 6; i++) wr(byte'(i));
    @(negedge clk);
    chk(tx_count == 5, "R3 shifter took head", int'(tx_count), 5);
    for (int s = 0; s < 4; s++) begin
      @(posedge clk); #1 tx_lvl_sel = 2'(s);
      @(negedge clk);
      chk(tx_hit == (s >= 2), "R10 tx level code", int'(tx_hit), int'(s >= 2));
    end
    for (int i = 6; i < 70; i++) wr(byte'(i));
    @(negedge clk);
    chk(tx_count == 64, "R3 full count", int'(tx_count), 64);
    chk(tx_full == 1'b1, "R3 tx_full", int'(tx_full), 1);

    // R4 / R5 loopback data path
    do_reset();
    #1 loopback = 1'b1;
    exp_q = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'hA5, 8'h5A, 8'h3C, 8'hC3, 8'h7E, 8'h11};
    foreach (exp_q[k]) wr(exp_q[k]);
    drain_tx();
    chk(rx_count == 10, "R4 rx count", int'(rx_count), 10);
    while (exp_q.size() > 0) rd_chk(exp_q.pop_front(), 1'b0, "R4 loopback byte");

    // R11 read on empty queue is ignored
    @(posedge clk); #1 rd_en = 1'b1;
    @(posedge clk); #1 rd_en = 1'b0;
    @(negedge clk);
    chk(rx_count == 0 && !rx_avail, "R11 empty read", int'(rx_count), 0);

    // R9 receive level codes with 8 bytes held
    for (int i = 0; i < 8; i++) wr(byte'(8'h40 + i));
    drain_tx();
    for (int s = 0; s < 8; s++) begin
      @(posedge clk); #1 rx_lvl_sel = 3'(s);
      @(negedge clk);
      chk(rx_hit == (s <= 2), "R9 rx level code", int'(rx_hit), int'(s <= 2));
    end
    for (int i = 0; i < 8; i++) rd_chk(byte'(8'h40 + i), 1'b0, "R11 read order");

    // R8 overrun
    do_reset();
    #1 loopback = 1'b1;
    for (int i = 0; i < 66; i++) begin
      @(negedge clk);
      while (tx_full) @(negedge clk);
      wr(byte'(i * 3 + 7));
    end
    drain_tx();
    chk(rx_count == 64, "R8 rx full", int'(rx_count), 64);
    chk(overrun == 1'b1, "R8 overrun set", int'(overrun), 1);
    for (int i = 0; i < 64; i++) rd_chk(byte'(i * 3 + 7), 1'b0, "R8 kept bytes");
    @(negedge clk);
    chk(overrun == 1'b1, "R8 overrun sticky", int'(overrun), 1);
    @(posedge clk); #1 ovr_clr = 1'b1;
    @(posedge clk); #1 ovr_clr = 1'b0;
    @(negedge clk);
    chk(overrun == 1'b0, "R8 overrun clear", int'(overrun), 0);

    // R7 / R6 external frames, divider 0
    do_reset();
    ext_frame(8'hA5, 1'b0, 1'b0);
    rd_chk(8'hA5, 1'b1, "R7 framing error");
    ext_frame(8'h3C, 1'b1, 1'b1);
    rd_chk(8'h3C, 1'b0, "R6 majority vote");
    @(posedge clk); #1 rxd = 1'b0;
    repeat (4) @(posedge clk);
    #1 rxd = 1'b1;
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk(rx_count == 0 && !rx_avail, "R6 false start", int'(rx_count), 0);

    model_on = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule